// File: doc/BRIEF.md
# Address Parity Guard

This block sits on a shared, active-low address bus and serves both ends of a transaction. On the requesting side it accepts a logical address and a one-cycle issue pulse. It can clear address bit 20 on request. In the next cycle it drives the inverted address, a strobe and two parity bits. One parity bit covers a 12-line upper group and the other covers a 21-line lower group.

On the observing side it recomputes both parity bits in any cycle where the strobe is seen. On a mismatch it pulls its address-error output low for one cycle. A mode bit is captured while reset is held and frozen when reset releases. When that mode bit is set, a fresh low level on the incoming error line makes the block raise a one-cycle abort.

Top module: `addr_parity_guard`

## Requirements
- R1: One cycle after `rq_go` is sampled high, `bus_strb_n_o` is low for that cycle and `bus_addr_n_o` carries the bitwise inverse of the (possibly masked) request address. In a cycle with no request, the strobe, every address line and both parity lines are high.
- R2: `bus_par_n_o[1]` covers address lines 35..24. It is high when an even number of those driven lines are low, and low otherwise.
- R3: `bus_par_n_o[0]` covers address lines 23..3 under the same rule as R2.
- R4: When `rq_mask20` is high with `rq_go`, logical bit 20 is forced to zero, so line 20 is driven high. Both parity bits are computed from the masked address.
- R5: When `obs_strb_n` is low and either received parity bit differs from the value the R2/R3 rule gives for `obs_addr_n`, `aerr_n_o` is low for exactly one cycle. That cycle is two cycles after the strobe cycle.
- R6: Parity and address values seen while `obs_strb_n` is high never cause an error indication.
- R7: `cfg_obs_en` is sampled on every clock edge while `rst_n` is low. The value sampled last before release is kept, and changes to `cfg_obs_en` after release have no effect.
- R8: With the captured mode set, a high-to-low change of `aerr_n_i` makes `abort_o` high for exactly one cycle, the cycle after the low level is first sampled. A level held low yields only one pulse.
- R9: With the captured mode clear, `abort_o` stays low whatever `aerr_n_i` does.
- R10: While `rst_n` is low, `aerr_n_o` is high, `abort_o` is low and `bus_strb_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; mode bit captured while low |
| cfg_obs_en | input | 1 | Error-observation mode, sampled during reset |
| rq_go | input | 1 | Issue a request this cycle |
| rq_mask20 | input | 1 | Clear logical address bit 20 for this request |
| rq_addr | input | 33 | Logical request address, bits 35..3 |
| bus_strb_n_o | output | 1 | Driven address strobe, active low |
| bus_addr_n_o | output | 33 | Driven address lines 35..3, active low |
| bus_par_n_o | output | 2 | Driven parity: [1] upper group, [0] lower group |
| obs_strb_n | input | 1 | Observed address strobe, active low |
| obs_addr_n | input | 33 | Observed address lines 35..3 |
| obs_par_n | input | 2 | Observed parity: [1] upper, [0] lower |
| aerr_n_o | output | 1 | Address-error indication, active low |
| aerr_n_i | input | 1 | Observed address-error line, active low |
| abort_o | output | 1 | One-cycle transaction abort |

## Verification
The hardest condition to reach is the abort path under a mode bit that was captured at reset release. Once reset has released, nothing at the ports can change that bit. The stimulus therefore runs two full reset sequences, one with the mode set and one with it clear. After each release it flips `cfg_obs_en` to show that the captured value holds. It then drives both single-cycle and held-low patterns on `aerr_n_i`. The observer side is driven apart from the requester, so parity can be corrupted in one group, in both groups, or only outside the strobe cycle. Back-to-back strobes show that error pulses stay aligned.

// File: rtl/apg_pkg.sv
package apg_pkg;

  localparam int LANES = 64;

  // Parity value for one group of active-low lines: high when an even
  // number of the lines in [lo, hi] sit low.
  function automatic logic grp_par(input logic [LANES-1:0] lines,
                                   input int lo, input int hi);
    int lows;
    lows = 0;
    for (int i = 0; i < LANES; i++)
      if (i >= lo && i <= hi && !lines[i]) lows++;
    return (lows % 2) == 0;
  endfunction

endpackage

// File: rtl/apg_req.sv
module apg_req #(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int GRP_SPLIT = 24,
  parameter int MASK_BIT  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 mask_b,
  input  logic [ADDR_HI:ADDR_LO] addr_l,
  output logic                 strb_n,
  output logic [ADDR_HI:ADDR_LO] addr_n,
  output logic [1:0]           par_n
);
  import apg_pkg::*;

  logic [ADDR_HI:ADDR_LO] masked;
  logic [ADDR_HI:ADDR_LO] drive_n;
  logic [LANES-1:0]       spread;
  logic [1:0]             par_d;

  always_comb begin
    masked = addr_l;
    if (mask_b) masked[MASK_BIT] = 1'b0;
    drive_n = ~masked;
    spread = '1;
    spread[ADDR_HI:ADDR_LO] = drive_n;
    par_d[1] = grp_par(spread, GRP_SPLIT, ADDR_HI);
    par_d[0] = grp_par(spread, ADDR_LO, GRP_SPLIT - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_n <= 1'b1;
      addr_n <= '1;
      par_n  <= 2'b11;
    end else if (go) begin
      strb_n <= 1'b0;
      addr_n <= drive_n;
      par_n  <= par_d;
    end else begin
      strb_n <= 1'b1;
      addr_n <= '1;
      par_n  <= 2'b11;
    end
  end
endmodule

// File: rtl/apg_obs.sv
module apg_obs #(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int GRP_SPLIT = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strb_n,
  input  logic [ADDR_HI:ADDR_LO] addr_n,
  input  logic [1:0]           par_n,
  output logic                 mism,
  output logic                 err_n
);
  import apg_pkg::*;

  logic [LANES-1:0] spread;
  logic [1:0]       want;
  logic             mm_q;
  logic             err_q;

  always_comb begin
    spread = '1;
    spread[ADDR_HI:ADDR_LO] = addr_n;
    want[1] = grp_par(spread, GRP_SPLIT, ADDR_HI);
    want[0] = grp_par(spread, ADDR_LO, GRP_SPLIT - 1);
    mism = !strb_n && (want != par_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      mm_q  <= mism;
      err_q <= mm_q;
    end
  end

  assign err_n = ~err_q;
endmodule

// File: rtl/apg_abort.sv
module apg_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic aerr_n_i,
  output logic en_q,
  output logic fresh_err,
  output logic abort
);
  logic prev_hi;

  // Loads continuously while reset is held; frozen once it releases.
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= cfg_en;
  end

  assign fresh_err = !aerr_n_i && prev_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi <= 1'b1;
      abort   <= 1'b0;
    end else begin
      prev_hi <= aerr_n_i;
      abort   <= en_q && fresh_err;
    end
  end
endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard #(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int GRP_SPLIT = 24,
  parameter int MASK_BIT  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_obs_en,
  input  logic                   rq_go,
  input  logic                   rq_mask20,
  input  logic [ADDR_HI:ADDR_LO] rq_addr,
  output logic                   bus_strb_n_o,
  output logic [ADDR_HI:ADDR_LO] bus_addr_n_o,
  output logic [1:0]             bus_par_n_o,
  input  logic                   obs_strb_n,
  input  logic [ADDR_HI:ADDR_LO] obs_addr_n,
  input  logic [1:0]             obs_par_n,
  output logic                   aerr_n_o,
  input  logic                   aerr_n_i,
  output logic                   abort_o
);
  logic strb_mism;
  logic obs_en;
  logic err_edge;

  apg_req #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
            .GRP_SPLIT(GRP_SPLIT), .MASK_BIT(MASK_BIT)) u_req (
    .clk(clk), .rst_n(rst_n), .go(rq_go), .mask_b(rq_mask20),
    .addr_l(rq_addr), .strb_n(bus_strb_n_o), .addr_n(bus_addr_n_o),
    .par_n(bus_par_n_o)
  );

  apg_obs #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
            .GRP_SPLIT(GRP_SPLIT)) u_obs (
    .clk(clk), .rst_n(rst_n), .strb_n(obs_strb_n), .addr_n(obs_addr_n),
    .par_n(obs_par_n), .mism(strb_mism), .err_n(aerr_n_o)
  );

  apg_abort u_abt (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_obs_en), .aerr_n_i(aerr_n_i),
    .en_q(obs_en), .fresh_err(err_edge), .abort(abort_o)
  );
endmodule

// File: rtl/apg_chk.sv
module apg_chk #(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int GRP_SPLIT = 24,
  parameter int MASK_BIT  = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rq_go,
  input logic                   rq_mask20,
  input logic                   bus_strb_n_o,
  input logic [ADDR_HI:ADDR_LO] bus_addr_n_o,
  input logic [1:0]             bus_par_n_o,
  input logic                   strb_mism,
  input logic                   aerr_n_o,
  input logic                   aerr_n_i,
  input logic                   obs_en,
  input logic                   err_edge,
  input logic                   abort_o
);
  AST_STRB_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rq_go |=> !bus_strb_n_o);  // R1
  AST_STRB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_go |=> bus_strb_n_o && (&bus_addr_n_o) && (&bus_par_n_o));  // R1
  AST_PAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strb_n_o |-> bus_par_n_o[1] ==
      (($countones(~bus_addr_n_o[ADDR_HI:GRP_SPLIT]) % 2) == 0));  // R2
  AST_PAR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strb_n_o |-> bus_par_n_o[0] ==
      (($countones(~bus_addr_n_o[GRP_SPLIT-1:ADDR_LO]) % 2) == 0));  // R3
  AST_MASK_B20: assert property (@(posedge clk) disable iff (!rst_n)
    rq_go && rq_mask20 |=> bus_addr_n_o[MASK_BIT]);  // R4
  AST_ERR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    strb_mism |-> ##2 !aerr_n_o);  // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !aerr_n_o |-> $past(strb_mism, 2));  // R6
  AST_MODE_FROZEN: assert property (@(posedge clk)
    rst_n && $past(rst_n) |-> $stable(obs_en));  // R7
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(err_edge));  // R8
  AST_ABORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> obs_en);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n && $past(!rst_n) |-> aerr_n_o && !abort_o && bus_strb_n_o);  // R10
endmodule

bind addr_parity_guard apg_chk #(
  .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
  .GRP_SPLIT(GRP_SPLIT), .MASK_BIT(MASK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_go(rq_go), .rq_mask20(rq_mask20),
  .bus_strb_n_o(bus_strb_n_o), .bus_addr_n_o(bus_addr_n_o),
  .bus_par_n_o(bus_par_n_o), .strb_mism(strb_mism), .aerr_n_o(aerr_n_o),
  .aerr_n_i(aerr_n_i), .obs_en(obs_en), .err_edge(err_edge),
  .abort_o(abort_o)
);

// File: tb/sim_addr_parity_guard.sv
module sim_addr_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_obs_en = 1'b1;
  logic        rq_go = 1'b0;
  logic        rq_mask20 = 1'b0;
  logic [35:3] rq_addr = '0;
  logic        bus_strb_n_o;
  logic [35:3] bus_addr_n_o;
  logic [1:0]  bus_par_n_o;
  logic        obs_strb_n = 1'b1;
  logic [35:3] obs_addr_n = '1;
  logic [1:0]  obs_par_n = 2'b11;
  logic        aerr_n_o;
  logic        aerr_n_i = 1'b1;
  logic        abort_o;

  int    checks = 0;
  int    fails = 0;
  string phase = "R10";

  always #10 clk = ~clk;

  addr_parity_guard u0 (.*);

  // Reference: count low lines by index, even count gives a high bit.
  function automatic bit lows_even(logic [35:3] lines, int lo, int hi);
    int n = 0;
    for (int i = lo; i <= hi; i++) if (lines[i] == 1'b0) n = n + 1;
    return (n % 2) == 0;
  endfunction

  // Model state
  bit          m_strb_n = 1;
  logic [35:3] m_addr_n = '1;
  bit [1:0]    m_par_n = 2'b11;
  bit          m_aerr_n = 1;
  bit          m_abort = 0;
  bit          m_en = 0;
  bit          m_prev = 1;
  bit          errq[$] = '{0};

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%h expected=%h at %0t",
               rq, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_strb_n = 1; m_addr_n = '1; m_par_n = 2'b11;
      m_aerr_n = 1; m_abort = 0; m_prev = 1; m_en = cfg_obs_en;
      errq = '{0};
    end else begin
      bit m_now;
      logic [35:3] a;
      m_now = !obs_strb_n &&
              ((obs_par_n[1] != lows_even(obs_addr_n, 24, 35)) ||
               (obs_par_n[0] != lows_even(obs_addr_n, 3, 23)));
      errq.push_back(m_now);
      m_aerr_n = !errq.pop_front();
      m_abort = m_en && !aerr_n_i && m_prev;
      m_prev = aerr_n_i;
      if (rq_go) begin
        a = rq_addr;
        if (rq_mask20) a[20] = 1'b0;
        m_strb_n = 0;
        m_addr_n = ~a;
        m_par_n = {lows_even(~a, 24, 35), lows_even(~a, 3, 23)};
      end else begin
        m_strb_n = 1; m_addr_n = '1; m_par_n = 2'b11;
      end
    end
    #2;
    chk("R1 strobe", 64'(bus_strb_n_o), 64'(m_strb_n));
    chk("R1/R4 address", 64'(bus_addr_n_o), 64'(m_addr_n));
    chk("R2 upper parity", 64'(bus_par_n_o[1]), 64'(m_par_n[1]));
    chk("R3 lower parity", 64'(bus_par_n_o[0]), 64'(m_par_n[0]));
    chk("R5/R6 error out", 64'(aerr_n_o), 64'(m_aerr_n));
    chk("R8/R9 abort", 64'(abort_o), 64'(m_abort));
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_req(logic [35:3] a, bit msk);
    @(negedge clk);
    rq_go = 1; rq_addr = a; rq_mask20 = msk;
    @(negedge clk);
    rq_go = 0; rq_mask20 = 0;
  endtask

  // Drive one observed strobe cycle; flip selects corrupted parity bits.
  task automatic send_obs(logic [35:3] an, bit [1:0] flip, bit strobe);
    @(negedge clk);
    obs_addr_n = an;
    obs_par_n = {lows_even(an, 24, 35), lows_even(an, 3, 23)} ^ flip;
    obs_strb_n = !strobe;
    @(negedge clk);
    obs_strb_n = 1;
  endtask

  task automatic pulse_err(int len);
    @(negedge clk);
    aerr_n_i = 0;
    wait_cyc(len);
    aerr_n_i = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired (phase %s)", phase);
    summary();
    $finish;
  end

  initial begin
    #1 rst_n = 0;
    // R10: reset holds outputs quiet despite bad strobes and error input
    phase = "R10";
    obs_strb_n = 0; obs_par_n = 2'b00; obs_addr_n = '1; aerr_n_i = 0;
    rq_go = 1;
    wait_cyc(3);
    rq_go = 0; obs_strb_n = 1; obs_par_n = 2'b11; aerr_n_i = 1;
    cfg_obs_en = 1;
    wait_cyc(1);
    rst_n = 1;
    // R7: mode captured as 1; later change must not matter
    phase = "R7";
    wait_cyc(1);
    cfg_obs_en = 0;
    pulse_err(1);
    wait_cyc(2);

    phase = "R1";
    send_req('0, 0);
    send_req('1, 0);
    send_req(33'h0_0000_0001, 0);
    phase = "R2";
    for (int i = 0; i < 6; i++) send_req(33'(1) << (21 + i), 0);
    phase = "R3";
    for (int i = 0; i < 6; i++) send_req(33'(1) << (i * 3), 0);
    phase = "R4";
    send_req('1, 1);
    send_req(33'(1) << 17, 1);
    send_req(33'(1) << 17, 0);
    phase = "R1";
    for (int i = 0; i < 8; i++) send_req(33'({$urandom(), $urandom()}), i[0]);
    @(negedge clk); rq_go = 1; rq_addr = 33'h1_2345_6789;
    @(negedge clk); rq_addr = 33'h0_FEDC_BA98; rq_mask20 = 1;
    @(negedge clk); rq_go = 0; rq_mask20 = 0;

    phase = "R5";
    send_obs('1, 2'b00, 1);
    send_obs(33'h0_F0F0_1234, 2'b10, 1);
    wait_cyc(3);
    send_obs(33'h1_0000_FFFF, 2'b01, 1);
    wait_cyc(3);
    send_obs('0, 2'b11, 1);
    @(negedge clk);
    obs_addr_n = 33'h0_1111_1111; obs_par_n = 2'b00; obs_strb_n = 0;
    @(negedge clk);
    obs_addr_n = 33'h0_2222_2222;
    obs_par_n = {lows_even(obs_addr_n, 24, 35), lows_even(obs_addr_n, 3, 23)};
    @(negedge clk);
    obs_par_n = ~obs_par_n;
    @(negedge clk); obs_strb_n = 1;
    wait_cyc(3);
    phase = "R6";
    send_obs(33'h0_ABCD_0000, 2'b11, 0);
    send_obs('0, 2'b01, 0);
    wait_cyc(3);

    phase = "R8";
    pulse_err(1);
    wait_cyc(2);
    pulse_err(4);
    wait_cyc(2);
    pulse_err(1);
    pulse_err(1);
    wait_cyc(3);

    // Second reset with mode clear
    phase = "R10";
    @(negedge clk); rst_n = 0; cfg_obs_en = 1;
    wait_cyc(2);
    cfg_obs_en = 0;
    wait_cyc(1);
    rst_n = 1;
    phase = "R9";
    wait_cyc(1);
    cfg_obs_en = 1;
    pulse_err(1);
    wait_cyc(2);
    pulse_err(3);
    send_obs(33'h0_0F0F_F0F0, 2'b10, 1);
    wait_cyc(4);

    summary();
    $finish;
  end
endmodule